// File: doc/BRIEF.md
# Configurable-Length SPI Master

This block is a single-master SPI controller with one slave-select line that it drives by itself. A host sets a transmit word, a bit count, the clock polarity and phase, and a divider value, then pulses `start`. The controller pulls slave select low and waits a lead interval. It then runs a start-stop serial clock for exactly the requested number of bits, waits a lag interval and releases slave select. The received bits are then available as a right-aligned word, and a sticky completion flag is set.

The bit count can change from one transaction to the next, anywhere from 4 to 32 bits. Only the low `xfer_len` bits of the transmit word are sent, most significant of those first. A count outside that range is refused with an error flag, and no bus activity follows. The serial clock runs at the system clock divided by `2*(clk_div+1)`. With `clk_div` = 0 it reaches half the system clock, which is enough for a 33 MHz bus from a 66 MHz or faster system clock.

Top module: `spi_xfer_master`

## Requirements
- R1: `cpol` sets the idle level of `sck`. With `cpha`=0 both sides sample on the odd-numbered edges (1st, 3rd, ...) and change data on the even ones. With `cpha`=1 data changes on odd edges and is sampled on even edges. All four combinations transfer data correctly.
- R2: `sck` changes only while `ss_n` is low, apart from following a change of `cpol` while idle. Each transaction produces exactly `2*xfer_len` clock edges, and `sck` ends at its idle level.
- R3: `ss_n` goes low on the clock edge that accepts a start and stays low until the transaction ends. `busy` is high for exactly that interval.
- R4: At least `clk_div+1` system clocks pass between `ss_n` falling and the first `sck` edge. At least the same interval passes between the last `sck` edge and `ss_n` rising.
- R5: The bit count `xfer_len` (4..32) is taken at start. `mosi` carries `tx_word[xfer_len-1]` first and `tx_word[0]` last. Bits of `tx_word` at and above `xfer_len` are not sent.
- R6: After a transaction, `rx_word` holds the sampled `miso` bits with the first received bit at position `xfer_len-1` and the last at bit 0. All bits above are zero.
- R7: A start while idle with `xfer_len` outside 4..32 sets `len_err`, leaves `busy` low and `ss_n` high, and produces no clock. The next accepted start clears `len_err`.
- R8: A `start` pulse while `busy` is high is ignored. The running transaction keeps its length, data and timing.
- R9: `done` is set on the edge where `ss_n` rises and stays set until the next accepted start clears it.
- R10: Each half period of `sck` is `clk_div+1` system clocks. `ss_n` stays low for exactly `(2*xfer_len+2)*(clk_div+1)` system clocks.
- R11: After reset `ss_n` is high, and `busy`, `done` and `len_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled each cycle |
| tx_word | input | 32 | Word to transmit, low `xfer_len` bits used |
| xfer_len | input | 6 | Transaction length in bits, valid 4..32 |
| cpol | input | 1 | Clock polarity (idle level of `sck`) |
| cpha | input | 1 | Clock phase (0: sample on leading edges, 1: on trailing edges) |
| clk_div | input | 8 | Half-period length minus one, in system clocks |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| rx_word | output | 32 | Received word, right-aligned |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Sticky completion flag |
| len_err | output | 1 | Last start was refused for an illegal length |

## Verification
The hardest case to reach is a phase and length combination in which the last data-change edge must be suppressed. The same goes for the case in which the first leading edge must not shift. Both appear only at particular lengths in particular modes, and a slave model is needed to reveal them. The bench sweeps every length from 4 to 32 in all four modes at two divider settings. Its bus-level slave model answers with its own word and records what it receives. A second hard case is a start request that lands in the middle of a transaction. The bench injects one, carrying a different length and data, partway through selected transfers and confirms that the result and the select duration are unchanged.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_RUN   = 2'd2,
    ST_TRAIL = 2'd3
  } spi_state_e;

  // A requested bit count is legal when it lies inside [lo, hi].
  function automatic logic len_ok(input int l, input int lo, input int hi);
    return (l >= lo) && (l <= hi);
  endfunction

  // Edge k (1-based) moves the transmit shifter to the next bit.
  // Phase 0: even edges except the final one.
  // Phase 1: odd edges except the first one, whose bit is already on the line.
  function automatic logic is_shift_edge(input int k, input int l, input logic ph);
    if (!ph) return ((k % 2) == 0) && (k < 2 * l);
    else     return ((k % 2) == 1) && (k > 1);
  endfunction

  // Edge k (1-based) captures the incoming bit.
  function automatic logic is_sample_edge(input int k, input logic ph);
    return ph ? ((k % 2) == 0) : ((k % 2) == 1);
  endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MIN_LEN = 4,
  parameter int LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             tick,
  output logic             run,
  output logic             sck,
  output logic             ss_n,
  output logic             busy,
  output logic             done,
  output logic             len_err,
  output logic             accept_evt,
  output logic             edge_evt,
  output logic             shift_evt,
  output logic             sample_evt,
  output logic             end_evt
);
  localparam int ECNT_W = LEN_W + 1;

  spi_state_e        state;
  logic [LEN_W-1:0]  len_q;
  logic              cpha_q;
  logic [ECNT_W-1:0] ecnt;
  logic              legal;
  int                k_next;

  assign legal      = len_ok(int'(len), MIN_LEN, DATA_W);
  assign accept_evt = start && (state == ST_IDLE) && legal;
  assign run        = (state != ST_IDLE);
  assign busy       = run;
  assign ss_n       = !run;
  assign k_next     = int'(ecnt) + 1;
  assign edge_evt   = (state == ST_RUN) && tick;
  assign shift_evt  = edge_evt && is_shift_edge(k_next, int'(len_q), cpha_q);
  assign sample_evt = edge_evt && is_sample_edge(k_next, cpha_q);
  assign end_evt    = (state == ST_TRAIL) && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      len_q   <= '0;
      cpha_q  <= 1'b0;
      ecnt    <= '0;
      sck     <= 1'b0;
      done    <= 1'b0;
      len_err <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          sck <= cpol;
          if (accept_evt) begin
            state   <= ST_LEAD;
            len_q   <= len;
            cpha_q  <= cpha;
            done    <= 1'b0;
            len_err <= 1'b0;
          end else if (start) begin
            len_err <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            state <= ST_RUN;
            ecnt  <= '0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            sck  <= ~sck;
            ecnt <= ecnt + 1'b1;
            if (k_next == 2 * int'(len_q)) state <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sh;

  // Left-justify the low len bits so the first bit sits at the top.
  function automatic logic [DATA_W-1:0] align_msb(input logic [DATA_W-1:0] w,
                                                  input int l);
    return w << (DATA_W - l);
  endfunction

  assign mosi = tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_word <= '0;
    end else if (load) begin
      tx_sh   <= align_msb(tx_word, int'(len));
      rx_word <= '0;
    end else begin
      if (shift_en)  tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
      if (sample_en) rx_word <= {rx_word[DATA_W-2:0], miso};
    end
  end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
  parameter int DATA_W  = 32,
  parameter int MIN_LEN = 4,
  parameter int DIV_W   = 8,
  parameter int LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic [DATA_W-1:0] rx_word,
  output logic              busy,
  output logic              done,
  output logic              len_err
);
  logic run, tick;
  logic accept_evt, edge_evt, shift_evt, sample_evt, end_evt;

  spi_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div), .tick(tick)
  );

  spi_ctrl #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len(xfer_len),
    .cpol(cpol), .cpha(cpha), .tick(tick), .run(run), .sck(sck),
    .ss_n(ss_n), .busy(busy), .done(done), .len_err(len_err),
    .accept_evt(accept_evt), .edge_evt(edge_evt), .shift_evt(shift_evt),
    .sample_evt(sample_evt), .end_evt(end_evt)
  );

  spi_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept_evt), .tx_word(tx_word),
    .len(xfer_len), .shift_en(shift_evt), .sample_en(sample_evt),
    .miso(miso), .mosi(mosi), .rx_word(rx_word)
  );
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
  parameter int DATA_W  = 32,
  parameter int MIN_LEN = 4,
  parameter int LEN_W   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] xfer_len,
  input logic             cpol,
  input logic             sck,
  input logic             ss_n,
  input logic             busy,
  input logic             done,
  input logic             len_err,
  input logic             accept_evt,
  input logic             edge_evt,
  input logic             end_evt
);
  logic [1:0]       warm;
  logic             sck_d;
  logic [LEN_W:0]   edges_seen;
  logic [LEN_W-1:0] len_c;
  logic             len_legal;

  assign len_legal = (int'(xfer_len) >= MIN_LEN) && (int'(xfer_len) <= DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm       <= '0;
      sck_d      <= 1'b0;
      edges_seen <= '0;
      len_c      <= '0;
    end else begin
      if (warm != 2'd3) warm <= warm + 1'b1;
      sck_d <= sck;
      if (accept_evt) begin
        edges_seen <= '0;
        len_c      <= xfer_len;
      end else if (!ss_n && (sck != sck_d)) begin
        edges_seen <= edges_seen + 1'b1;
      end
    end
  end

  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && ss_n && $past(ss_n)) |-> (sck == $past(cpol)));

  p_sck_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && ss_n && $past(ss_n) && $past(ss_n, 2) &&
     $past(cpol) == $past(cpol, 2)) |-> $stable(sck));

  p_edge_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && $rose(ss_n)) |-> (edges_seen == {len_c, 1'b0}));

  p_busy_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy == !ss_n));

  p_lead_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |-> !$past(accept_evt));

  p_lag_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && $rose(ss_n)) |-> $stable(sck));

  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !len_legal) |=> (!busy && len_err));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len_legal) |=> (busy && !len_err && !done));

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !end_evt) |=> busy);

  p_done_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && $fell(busy)) |-> done);
endmodule

bind spi_xfer_master spi_xfer_master_chk #(
  .DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
  .cpol(cpol), .sck(sck), .ss_n(ss_n), .busy(busy), .done(done),
  .len_err(len_err), .accept_evt(accept_evt), .edge_evt(edge_evt),
  .end_evt(end_evt)
);

// File: tb/sim_spi_xfer_master.sv
`timescale 1ns/1ps
module sim_spi_xfer_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tx_word = '0;
  logic [5:0]  xfer_len = 6'd8;
  logic        cpol = 1'b0;
  logic        cpha = 1'b0;
  logic [7:0]  clk_div = '0;
  logic        miso = 1'b0;
  logic        sck, mosi, ss_n, busy, done, len_err;
  logic [31:0] rx_word;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  spi_xfer_master u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .xfer_len(xfer_len), .cpol(cpol), .cpha(cpha), .clk_div(clk_div),
    .miso(miso), .sck(sck), .mosi(mosi), .ss_n(ss_n), .rx_word(rx_word),
    .busy(busy), .done(done), .len_err(len_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bus-level slave model, sampled at the falling system clock edge.
  logic [31:0] s_word = '0;
  logic [31:0] s_got = '0;
  int          s_len = 8;
  logic        s_cpha = 1'b0;
  int          s_k = 0;
  int          s_bi = 0;
  logic        s_prev_sck = 1'b0;
  logic        s_prev_ss = 1'b1;

  always @(negedge clk) begin
    if (!ss_n && s_prev_ss) begin
      s_k   = 0;
      s_got = '0;
      if (!s_cpha) begin
        miso = s_word[s_len-1];
        s_bi = s_len - 2;
      end else begin
        s_bi = s_len - 1;
      end
    end else if (!ss_n && sck != s_prev_sck) begin
      s_k++;
      if ((s_k % 2 == 1) != s_cpha) begin
        s_got = {s_got[30:0], mosi};
      end else if (s_cpha || s_k < 2 * s_len) begin
        if (s_bi >= 0) miso = s_word[s_bi];
        s_bi--;
      end
    end
    s_prev_sck = sck;
    s_prev_ss  = ss_n;
  end

  function automatic logic [31:0] low_mask(input int l);
    return (l >= 32) ? 32'hFFFF_FFFF : ((32'd1 << l) - 32'd1);
  endfunction

  task automatic xfer(input logic [31:0] tx, input logic [31:0] sw, input int l,
                      input logic pol, input logic ph, input int dv, input logic poke);
    int cyc;
    s_word = sw; s_len = l; s_cpha = ph;
    tx_word = tx; xfer_len = 6'(l); cpol = pol; cpha = ph; clk_div = 8'(dv);
    repeat (3) @(negedge clk);
    chk("R1 idle sck level", {31'd0, sck}, {31'd0, pol});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 done cleared on start", {31'd0, done}, 32'd0);
    chk("R3 busy on accept", {30'd0, busy, ss_n}, 32'd2);
    cyc = 0;
    while (!ss_n && cyc < 5000) begin
      cyc++;
      if (poke && cyc == 5) begin
        start = 1'b1; tx_word = ~tx; xfer_len = 6'd4;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R10 select low duration", cyc, (2 * l + 2) * (dv + 1));
    chk("R2 edge count", s_k, 2 * l);
    chk("R5 data seen by slave", s_got, tx & low_mask(l));
    chk("R6 received word", rx_word, sw & low_mask(l));
    chk("R2 sck back at idle", {31'd0, sck}, {31'd0, pol});
    chk("R9 done after release", {30'd0, done, busy}, 32'd2);
    if (poke) chk("R8 mid-transfer start ignored", rx_word, sw & low_mask(l));
  endtask

  task automatic bad_len(input int l);
    xfer_len = 6'(l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 len_err set", {31'd0, len_err}, 32'd1);
    repeat (4) begin
      @(negedge clk);
      chk("R7 no transfer", {29'd0, busy, ss_n, done}, 32'd3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset state", {28'd0, ss_n, busy, done, len_err}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 state after reset release", {28'd0, ss_n, busy, done, len_err}, 32'h8);

    for (int dv = 0; dv <= 2; dv += 2)
      for (int m = 0; m < 4; m++)
        for (int l = 4; l <= 32; l++) begin
          logic [31:0] tx, sw;
          tx = 32'h9E37_79B9 * (l + 7 * m + 31 * dv) ^ 32'hA5C3_0F96;
          sw = 32'h6C07_8965 * (l + 3 * m + 1) ^ {l[7:0], 24'h5A3C96};
          xfer(tx, sw, l, m[1], m[0], dv, (dv == 2) && (l % 7 == 0));
        end

    xfer(32'hFFFF_FFF0, 32'h0000_000F, 4, 1'b0, 1'b0, 5, 1'b1);
    xfer(32'h8000_0001, 32'h7FFF_FFFE, 32, 1'b1, 1'b1, 1, 1'b0);

    bad_len(0);
    bad_len(3);
    bad_len(33);
    bad_len(63);
    xfer(32'h0000_00A5, 32'h0000_003C, 8, 1'b0, 1'b1, 0, 1'b0);
    chk("R7 len_err cleared by accepted start", {31'd0, len_err}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule